// File: doc/BRIEF.md
# Peripheral Interrupt Level Router

This block gathers up to 96 level-sensitive peripheral interrupt lines, grouped into 32-bit banks, and steers each one to one of seven core priority levels. Level 0 is the most urgent of the seven and level 6 the least. Every source has a 4-bit routing field. A source counts as active when its sampled status bit and its enable bit are both set. Each level output is the OR of the active sources that are routed to that level.

A second path raises a wake request. It is the OR, over all banks, of status AND wake-enable, and the enable masks have no part in it. The core asks which source to service by placing a level number on the identify port. One cycle later the port returns the lowest-numbered active source routed to that level, together with a valid flag.

All state sits behind a flat word-addressed register port. That port has a write strobe and a registered read path.

Top module: `sic_router`

## Requirements
- R1: In the cycle after a synchronous reset, all routing fields, enable masks and wake-enable masks read 0, and `lvl_req`, `wake_req` and `id_valid` are 0.
- R2: Source n has its routing field at word address n/8, bits (n mod 8)*4 to (n mod 8)*4+3. A field value v from 0 to 6 routes the source to `lvl_req[v]`. Values 7 to 15 route it to no level.
- R3: `lvl_req[v]` is the OR of all sources whose status bit and enable bit are both 1 and whose field equals v. An `irq_in` change shows on `lvl_req` after two rising edges.
- R4: A routing-field write changes `lvl_req` at the first rising edge after the edge that stores it. Levels that no source leaves or joins keep their value.
- R5: One edge after `id_level` is presented, `id_src` holds the lowest source index that is active and routed to that level, and `id_valid` is 1.
- R6: `id_valid` is 0 when no active source is routed to the queried level, and also when `id_level` is 7.
- R7: `wake_req` is the OR over every source of status AND wake-enable. It is 1 even when the source's enable bit is 0, and it appears after two edges from `irq_in`.
- R8: The status words at addresses 20 to 22 read the sampled `irq_in` bits, one bank per word with bit k = source 32*bank+k. Writes to these words have no effect.
- R9: The register map is as follows. Words 0 to 11 hold the routing fields. Words 16 to 18 hold the enable masks for banks 0 to 2. Words 24 to 26 hold the wake-enable masks. `rd_data` shows the word one edge after `rd_addr`, and an unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 96 | Peripheral interrupt lines, level sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Registered read data |
| id_level | input | 3 | Level number to identify (0 to 6) |
| id_src | output | 7 | Lowest active source index at the queried level |
| id_valid | output | 1 | An active source exists at the queried level |
| lvl_req | output | 7 | Per-level interrupt requests |
| wake_req | output | 1 | Wake request |

## Verification
A routing-field write can land in the same cycle as an identify query on the same level. The new field must then decide both the level request and the identify answer one edge later. The bench provokes this by moving a pending source from one level to another while it holds `id_level` on the old level. It samples between edges to see that the old level and the identify flag drop on the same edge, and that the new level rises on that edge. Wake and level requests also coincide. The bench gives one source a wake-enable but no enable bit, and judges that `wake_req` rises while `lvl_req` stays 0.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Word map of the register port; the routing words start at 0.
  localparam int SIC_MASK_BASE   = 16;
  localparam int SIC_STATUS_BASE = 20;
  localparam int SIC_WAKE_BASE   = 24;
  localparam int SIC_ADDR_W      = 5;
  localparam int SIC_DATA_W      = 32;
  localparam int SIC_NUM_LEVELS  = 7;
  localparam int SIC_LEVEL_W     = 3;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int BANK_W  = 32,
  parameter int FIELD_W = 4,
  parameter int DATA_W  = SIC_DATA_W,
  parameter int ADDR_W  = SIC_ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         irq_in,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_SRC*FIELD_W-1:0] field_flat,
  output logic [NUM_SRC-1:0]         mask_flat,
  output logic [NUM_SRC-1:0]         wake_flat,
  output logic [NUM_SRC-1:0]         status_flat
);
  localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int FPR       = DATA_W / FIELD_W;
  localparam int NUM_AREG  = (NUM_SRC + FPR - 1) / FPR;

  logic [DATA_W-1:0] route_q  [NUM_AREG];
  logic [BANK_W-1:0] mask_q   [NUM_BANKS];
  logic [BANK_W-1:0] wake_q   [NUM_BANKS];
  logic [BANK_W-1:0] status_q [NUM_BANKS];
  logic [NUM_BANKS*BANK_W-1:0] irq_pad;
  logic [NUM_BANKS*BANK_W-1:0] mask_all, wake_all, status_all;
  logic [NUM_AREG*DATA_W-1:0]  field_all;
  logic [DATA_W-1:0]           rd_next;

  always_comb begin
    irq_pad = '0;
    irq_pad[NUM_SRC-1:0] = irq_in;
  end

  for (genvar a = 0; a < NUM_AREG; a++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst)
        route_q[a] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(a))
        route_q[a] <= wr_data;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[b]   <= '0;
        wake_q[b]   <= '0;
        status_q[b] <= '0;
      end else begin
        status_q[b] <= irq_pad[b*BANK_W +: BANK_W];
        if (wr_en && wr_addr == ADDR_W'(SIC_MASK_BASE + b))
          mask_q[b] <= wr_data[BANK_W-1:0];
        if (wr_en && wr_addr == ADDR_W'(SIC_WAKE_BASE + b))
          wake_q[b] <= wr_data[BANK_W-1:0];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      mask_all[b*BANK_W +: BANK_W]   = mask_q[b];
      wake_all[b*BANK_W +: BANK_W]   = wake_q[b];
      status_all[b*BANK_W +: BANK_W] = status_q[b];
    end
    for (int a = 0; a < NUM_AREG; a++)
      field_all[a*DATA_W +: DATA_W] = route_q[a];
  end

  assign mask_flat   = mask_all[NUM_SRC-1:0];
  assign wake_flat   = wake_all[NUM_SRC-1:0];
  assign status_flat = status_all[NUM_SRC-1:0];
  assign field_flat  = field_all[NUM_SRC*FIELD_W-1:0];

  always_comb begin
    rd_next = '0;
    for (int a = 0; a < NUM_AREG; a++)
      if (rd_addr == ADDR_W'(a)) rd_next = route_q[a];
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_addr == ADDR_W'(SIC_MASK_BASE + b))   rd_next = DATA_W'(mask_q[b]);
      if (rd_addr == ADDR_W'(SIC_STATUS_BASE + b)) rd_next = DATA_W'(status_q[b]);
      if (rd_addr == ADDR_W'(SIC_WAKE_BASE + b))   rd_next = DATA_W'(wake_q[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int NUM_SRC = 96,
  parameter int FIELD_W = 4,
  parameter int NUM_LVL = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         active,
  input  logic [NUM_SRC-1:0]         wake_src,
  input  logic [NUM_SRC*FIELD_W-1:0] field_flat,
  output logic [NUM_LVL-1:0]         lvl_req,
  output logic                       wake_req
);
  logic [NUM_LVL-1:0] hit;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_SRC-1:0] sel;
    always_comb begin
      for (int n = 0; n < NUM_SRC; n++)
        sel[n] = (field_flat[n*FIELD_W +: FIELD_W] == FIELD_W'(l));
    end
    assign hit[l] = |(active & sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_req  <= '0;
      wake_req <= 1'b0;
    end else begin
      lvl_req  <= hit;
      wake_req <= |wake_src;
    end
  end
endmodule

// File: rtl/sic_ident.sv
module sic_ident #(
  parameter int NUM_SRC = 96,
  parameter int FIELD_W = 4,
  parameter int NUM_LVL = 7,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         active,
  input  logic [NUM_SRC*FIELD_W-1:0] field_flat,
  input  logic [LVL_W-1:0]           id_level,
  output logic [IDX_W-1:0]           id_src,
  output logic                       id_valid
);
  logic             found;
  logic [IDX_W-1:0] pick;
  logic             lvl_ok;

  assign lvl_ok = (32'(id_level) < NUM_LVL);

  // Descending scan: the last match written is the lowest index.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (lvl_ok && active[n] &&
          field_flat[n*FIELD_W +: FIELD_W] == FIELD_W'(id_level)) begin
        found = 1'b1;
        pick  = IDX_W'(n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_src   <= '0;
      id_valid <= 1'b0;
    end else begin
      id_src   <= pick;
      id_valid <= found;
    end
  end
endmodule

// File: rtl/sic_router.sv
module sic_router
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int BANK_W  = 32,
  parameter int FIELD_W = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        irq_in,
  input  logic                      wr_en,
  input  logic [SIC_ADDR_W-1:0]     wr_addr,
  input  logic [SIC_DATA_W-1:0]     wr_data,
  input  logic [SIC_ADDR_W-1:0]     rd_addr,
  output logic [SIC_DATA_W-1:0]     rd_data,
  input  logic [SIC_LEVEL_W-1:0]    id_level,
  output logic [IDX_W-1:0]          id_src,
  output logic                      id_valid,
  output logic [SIC_NUM_LEVELS-1:0] lvl_req,
  output logic                      wake_req
);
  logic [NUM_SRC*FIELD_W-1:0] field_flat;
  logic [NUM_SRC-1:0]         mask_flat, wake_flat, status_flat;
  logic [NUM_SRC-1:0]         active_w, wake_src_w;

  sic_regs #(
    .NUM_SRC(NUM_SRC), .BANK_W(BANK_W), .FIELD_W(FIELD_W)
  ) u_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .field_flat(field_flat), .mask_flat(mask_flat),
    .wake_flat(wake_flat), .status_flat(status_flat)
  );

  assign active_w   = status_flat & mask_flat;
  assign wake_src_w = status_flat & wake_flat;

  sic_route #(
    .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .NUM_LVL(SIC_NUM_LEVELS)
  ) u_route (
    .clk(clk), .rst(rst), .active(active_w), .wake_src(wake_src_w),
    .field_flat(field_flat), .lvl_req(lvl_req), .wake_req(wake_req)
  );

  sic_ident #(
    .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W),
    .NUM_LVL(SIC_NUM_LEVELS), .LVL_W(SIC_LEVEL_W)
  ) u_ident (
    .clk(clk), .rst(rst), .active(active_w), .field_flat(field_flat),
    .id_level(id_level), .id_src(id_src), .id_valid(id_valid)
  );
endmodule

// File: rtl/sic_router_chk.sv
module sic_router_chk #(
  parameter int NUM_SRC = 96,
  parameter int NUM_LVL = 7,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] irq_in,
  input logic [LVL_W-1:0]   id_level,
  input logic [IDX_W-1:0]   id_src,
  input logic               id_valid,
  input logic [NUM_LVL-1:0] lvl_req,
  input logic               wake_req,
  input logic [NUM_SRC-1:0] active,
  input logic [NUM_SRC-1:0] wake_src,
  input logic [NUM_SRC-1:0] status_flat
);
  logic [NUM_SRC-1:0] prev_active;

  always_ff @(posedge clk) begin
    if (rst) prev_active <= '0;
    else     prev_active <= active;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (lvl_req == '0 && !wake_req && !id_valid));

  p_level_needs_active_r3: assert property (@(posedge clk) disable iff (rst)
    (prev_active == '0) |-> (lvl_req == '0));

  p_ident_is_active_r5: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> prev_active[id_src]);

  p_ident_level_range_r6: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> (32'($past(id_level)) < NUM_LVL));

  p_wake_follows_src_r7: assert property (@(posedge clk) disable iff (rst)
    wake_req == (|$past(wake_src)));

  p_status_samples_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_flat == $past(irq_in)));
endmodule

bind sic_router sic_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_LVL(sic_pkg::SIC_NUM_LEVELS), .LVL_W(sic_pkg::SIC_LEVEL_W)
) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .id_level(id_level),
  .id_src(id_src), .id_valid(id_valid), .lvl_req(lvl_req),
  .wake_req(wake_req), .active(active_w), .wake_src(wake_src_w),
  .status_flat(status_flat)
);

// File: tb/sic_router_bench.sv
`timescale 1ns/1ps
module sic_router_bench;
  localparam int NSRC = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  id_level = '0;
  logic [6:0]  id_src;
  logic        id_valid;
  logic [6:0]  lvl_req;
  logic        wake_req;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_route [12];
  logic [31:0] m_mask  [3];
  logic [31:0] m_wake  [3];

  always #2 clk = ~clk;

  sic_router u_sic_router (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .id_level(id_level), .id_src(id_src), .id_valid(id_valid),
    .lvl_req(lvl_req), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] fld(input int n);
    return m_route[n/8][(n%8)*4 +: 4];
  endfunction

  function automatic logic act_src(input int n);
    return irq_in[n] & m_mask[n/32][n%32];
  endfunction

  function automatic logic [6:0] exp_lvl();
    logic [6:0] r = '0;
    for (int n = 0; n < NSRC; n++)
      if (act_src(n) && fld(n) < 4'd7) r[fld(n)] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_wake();
    logic w = 1'b0;
    for (int n = 0; n < NSRC; n++) w |= irq_in[n] & m_wake[n/32][n%32];
    return w;
  endfunction

  // Returns {valid, index}.
  function automatic logic [7:0] exp_id(input logic [2:0] lv);
    for (int n = 0; n < NSRC; n++)
      if (lv != 3'd7 && act_src(n) && fld(n) == {1'b0, lv}) return {1'b1, 7'(n)};
    return 8'h00;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a < 5'd12) m_route[a] = d;
    else if (a >= 5'd16 && a <= 5'd18) m_mask[a-16] = d;
    else if (a >= 5'd24 && a <= 5'd26) m_wake[a-24] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_field(input int n, input logic [3:0] v);
    logic [31:0] w = m_route[n/8];
    w[(n%8)*4 +: 4] = v;
    wr(5'(n/8), w);
  endtask

  task automatic check_id(input string req, input logic [2:0] lv);
    logic [7:0] e;
    @(negedge clk);
    id_level = lv;
    @(negedge clk);
    e = exp_id(lv);
    chk(req, {24'd0, id_valid, id_src}, {24'd0, e});
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20241));
    for (int i = 0; i < 12; i++) m_route[i] = '0;
    for (int i = 0; i < 3; i++) begin m_mask[i] = '0; m_wake[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 lvl_req", 32'(lvl_req), 0);
    chk("R1 wake_req", 32'(wake_req), 0);
    chk("R1 id_valid", 32'(id_valid), 0);
    rd(5'd17, d); chk("R1 mask word", d, 0);
    rd(5'd25, d); chk("R1 wake word", d, 0);
    rd(5'd3, d);  chk("R1 route word", d, 0);

    // R2 field location: source 13 -> word 1 bits 23:20, value 5
    irq_in[13] = 1'b1;
    wr(5'd16, 32'h0000_2000);
    set_field(13, 4'd5);
    settle();
    chk("R2 src13 to level5", 32'(lvl_req), 32'h20);
    rd(5'd1, d); chk("R2 field position", d, 32'h0050_0000);
    set_field(13, 4'd9);
    settle();
    chk("R2 value 9 routes nowhere", 32'(lvl_req), 0);
    // R2 highest source: 95 -> word 11 bits 31:28
    irq_in[95] = 1'b1;
    wr(5'd18, 32'h8000_0000);
    set_field(95, 4'd6);
    settle();
    chk("R2 src95 to level6", 32'(lvl_req), 32'h40);

    // R3 two-edge latency from irq_in, mask gating
    set_field(13, 4'd2);
    settle();
    @(negedge clk);
    irq_in[13] = 1'b0;
    @(negedge clk);
    chk("R3 one edge: unchanged", 32'(lvl_req), 32'h44);
    @(negedge clk);
    chk("R3 two edges: dropped", 32'(lvl_req), 32'h40);
    irq_in[14] = 1'b1;
    settle();
    chk("R3 unmasked source ignored", 32'(lvl_req), 32'(exp_lvl()));

    // R4 + R5 concurrent: move src 95 from level 6 to 1 while querying level 6
    irq_in[13] = 1'b1;
    settle();
    @(negedge clk);
    id_level = 3'd6;
    wr_en = 1'b1; wr_addr = 5'd11;
    wr_data = m_route[11]; wr_data[31:28] = 4'd1;
    m_route[11] = wr_data;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 before next edge: old", 32'(lvl_req), 32'h44);
    chk("R5 ident still old level", {24'd0, id_valid, id_src}, {24'd0, 1'b1, 7'd95});
    @(negedge clk);
    chk("R4 moved to level1, level2 kept", 32'(lvl_req), 32'h06);
    chk("R6 ident drops with field move", 32'(id_valid), 0);

    // R5 lowest index wins: sources 40 and 70 at level 3
    irq_in[40] = 1'b1; irq_in[70] = 1'b1;
    wr(5'd17, 32'h0000_0100);
    wr(5'd18, 32'h8000_0040);
    set_field(40, 4'd3);
    set_field(70, 4'd3);
    settle();
    check_id("R5 lowest index at level3", 3'd3);
    chk("R5 id_src is 40", 32'(id_src), 40);
    check_id("R6 empty level4", 3'd4);
    check_id("R6 level 7 query", 3'd7);

    // R7 wake without mask: source 50
    irq_in[50] = 1'b1;
    wr(5'd25, 32'h0004_0000);
    settle();
    chk("R7 wake set while masked", 32'(wake_req), 1);
    chk("R7 level unaffected", 32'(lvl_req), 32'(exp_lvl()));
    irq_in[50] = 1'b0;
    settle();
    chk("R7 wake clears", 32'(wake_req), 0);

    // R8 status read-only
    wr(5'd21, 32'hFFFF_FFFF);
    rd(5'd21, d); chk("R8 status ignores write", d, irq_in[63:32]);
    rd(5'd22, d); chk("R8 status bank2", d, irq_in[95:64]);

    // R9 map and unmapped
    rd(5'd18, d); chk("R9 mask bank2", d, m_mask[2]);
    rd(5'd15, d); chk("R9 unmapped reads 0", d, 0);
    rd(5'd31, d); chk("R9 unmapped top", d, 0);

    // Random phase
    for (int it = 0; it < 60; it++) begin
      logic [4:0] a;
      for (int k = 0; k < 3; k++) begin
        int sel = $urandom_range(0, 2);
        if (sel == 0) wr(5'($urandom_range(0, 11)), $urandom & ($urandom | 32'h7777_7777));
        else if (sel == 1) wr(5'(16 + $urandom_range(0, 2)), $urandom);
        else wr(5'(24 + $urandom_range(0, 2)), $urandom & $urandom & $urandom);
      end
      @(negedge clk);
      irq_in = {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom};
      settle();
      chk("R3 random levels", 32'(lvl_req), 32'(exp_lvl()));
      chk("R7 random wake", 32'(wake_req), 32'(exp_wake()));
      check_id("R5 random ident", 3'($urandom_range(0, 7)));
      a = 5'($urandom_range(0, 31));
      rd(a, d);
      if (a < 5'd12) chk("R9 random route word", d, m_route[a]);
      else if (a >= 5'd16 && a <= 5'd18) chk("R9 random mask word", d, m_mask[a-16]);
      else if (a >= 5'd20 && a <= 5'd22) chk("R8 random status word", d, irq_in[(a-20)*32 +: 32]);
      else if (a >= 5'd24 && a <= 5'd26) chk("R9 random wake word", d, m_wake[a-24]);
      else chk("R9 random unmapped", d, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule